// File: doc/BRIEF.md
# Card contact activation sequencer

This block powers up and powers down the contacts of one ISO 7816 smart card slot in a fixed, timed order. It runs on the internal oscillator clock. Its time unit T is `T_CYC` clock cycles, which is one period of the oscillator divided by 64 at the default `T_CYC = 64`. Every step of the sequence falls on a multiple of T/2, and the first step follows the request by one clock, which is T/64 at the default. `T_CYC` must be even and at least 4.

The host holds `start_req` high to ask for a session and drops it to end the session. The block accepts a request only when the card is present and the supply supervisor is quiet. During activation it switches on, in order, the converter, the card supply, the I/O line, and then the clock together with reset control. Deactivation removes them in the reverse order and then grounds the contacts. A fault during a session forces the same shutdown order. It also gives a one-cycle `fault_pulse`, which the surrounding logic uses to clear the start bit and set the protection flag. The faults are supply overcurrent, reset-pin overcurrent, overheat, supply alarm, or loss of card presence.

The converter is shared with a second slot, and `other_active` tells this slot whether that slot is in session. The block carries no data stream, so it has no valid/ready handshake. All pins are plain control and status levels that are sampled on every clock.

Top module: `card_contact_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is low.
- R2: With `start_req` high, no activation starts if `card_present` is low or `supply_alarm` is high. All outputs stay low.
- R3: Let the clock edge that accepts a request be edge 0. `conv_en` is high after edge 0, provided `other_active` was low at that edge. `vcc_en` goes high after edge 3·T/2 and `io_en` after edge 7·T/2. `clk_en`, `rst_en` and `active` go high together after edge 4·T.
- R4: If `other_active` is high at the accepting edge, `conv_en` stays low for the whole session and its shutdown.
- R5: Let the edge that samples `start_req` low during a session be edge 0. `rst_en` is low after edge 0. `clk_en` is low after edge T/2, `io_en` after edge T and `vcc_en` after edge 3·T/2. `active` is low after edge 7·T/2, which is the grounding step.
- R6: At the grounding step, `conv_en` falls if `other_active` is low. Otherwise `conv_en` stays high while the slot is idle. It falls after the first edge that samples `other_active` low.
- R7: During activation or a session, any of `vcc_overcur`, `rst_overcur`, `overheat` or `supply_alarm` going high starts the R5 shutdown from the edge that samples it. So does `card_present` going low. `fault_pulse` is high for exactly the one cycle after that edge.
- R8: After a fault shutdown, a `start_req` that is still high starts nothing. `start_req` must first be sampled low, and then a new request is accepted.
- R9: A request raised during a shutdown is held off. The shutdown completes on its normal timing. The request is then accepted at the edge after the grounding step, and that edge is edge 0 of R3.
- R10: If `start_req` drops during activation, the R5 timing applies from that edge. Contacts that were not yet on stay off. `active` never rises, even when the drop is sampled on the edge that would have completed activation.
- R11: While idle, the fault inputs have no effect. All outputs stay low and `fault_pulse` does not fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_req | input | 1 | Host session request level |
| card_present | input | 1 | Card detected in slot |
| supply_alarm | input | 1 | Supply supervisor active (drop-out) |
| vcc_overcur | input | 1 | Card supply overcurrent |
| rst_overcur | input | 1 | Reset contact overcurrent |
| overheat | input | 1 | Die overheat |
| other_active | input | 1 | Other slot is in session |
| conv_en | output | 1 | This slot holds the converter on |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | I/O line enable |
| clk_en | output | 1 | Card clock enable |
| rst_en | output | 1 | Reset contact released to control |
| active | output | 1 | Session active flag |
| fault_pulse | output | 1 | One-cycle emergency event |

## Verification
A wrong step counter or state shows up as one enable rising or falling one or more cycles away from its multiple of T/2. It therefore appears within one sequence, at most 4·T cycles after the request. The bench sweeps the stop point across every step boundary of activation, including the edge that would complete it. It also applies each of the five fault sources in both the activation and the session phase. A lost lockout or converter hold-over appears as an unexpected rise, or a missing fall, of `conv_en` or `vcc_en` within a few cycles of the grounding step.

// File: rtl/cseq_pkg.sv
package cseq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RAMP  = 2'd1,
    SQ_LIVE  = 2'd2,
    SQ_DRAIN = 2'd3
  } sq_state_t;

  typedef struct packed {
    logic vcc;
    logic io;
    logic clk;
    logic rst;
    logic act;
  } contact_t;
endpackage

// File: rtl/cseq_timer.sv
module cseq_timer #(
  parameter int CW   = 9,
  parameter int CMAX = 255
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] LIMIT = CW'(CMAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clear) begin
      cnt <= '0;
    end else if (cnt != LIMIT) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cseq_gate.sv
module cseq_gate
  import cseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  sq_state_t state,
  input  logic      start_req,
  input  logic      card_present,
  input  logic      supply_alarm,
  input  logic      vcc_overcur,
  input  logic      rst_overcur,
  input  logic      overheat,
  output logic      accept,
  output logic      stop,
  output logic      emerg
);
  logic lock_q;
  logic fault_any;
  logic in_sess;

  always_comb begin
    fault_any = vcc_overcur | rst_overcur | overheat | supply_alarm | ~card_present;
    in_sess   = (state == SQ_RAMP) || (state == SQ_LIVE);
    emerg     = in_sess && fault_any;
    stop      = in_sess && !start_req && !fault_any;
    accept    = (state == SQ_IDLE) && start_req && card_present && !supply_alarm && !lock_q;
  end

  // A fault shutdown locks out restarts until the request is seen low.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
    end else if (emerg) begin
      lock_q <= 1'b1;
    end else if (!start_req) begin
      lock_q <= 1'b0;
    end
  end
endmodule

// File: rtl/cseq_fsm.sv
module cseq_fsm
  import cseq_pkg::*;
#(
  parameter int T_CYC = 64,
  parameter int CW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          stop,
  input  logic          emerg,
  input  logic [CW-1:0] cnt,
  output sq_state_t     state,
  output contact_t      ct,
  output logic          fault_pulse,
  output logic          done
);
  localparam int HALF = T_CYC / 2;
  localparam logic [CW-1:0] K_VCC_ON  = CW'(3 * HALF - 1);
  localparam logic [CW-1:0] K_IO_ON   = CW'(7 * HALF - 1);
  localparam logic [CW-1:0] K_LIVE    = CW'(4 * T_CYC - 1);
  localparam logic [CW-1:0] K_CLK_OFF = CW'(HALF - 1);
  localparam logic [CW-1:0] K_IO_OFF  = CW'(T_CYC - 1);
  localparam logic [CW-1:0] K_VCC_OFF = CW'(3 * HALF - 1);
  localparam logic [CW-1:0] K_GROUND  = CW'(7 * HALF - 1);

  assign done = (state == SQ_DRAIN) && (cnt == K_GROUND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= SQ_IDLE;
      ct          <= '0;
      fault_pulse <= 1'b0;
    end else begin
      fault_pulse <= 1'b0;
      case (state)
        SQ_IDLE: begin
          if (accept) state <= SQ_RAMP;
        end
        SQ_RAMP, SQ_LIVE: begin
          if (emerg || stop) begin
            state       <= SQ_DRAIN;
            ct.rst      <= 1'b0;
            fault_pulse <= emerg;
          end else if (state == SQ_RAMP) begin
            if (cnt == K_VCC_ON) ct.vcc <= 1'b1;
            if (cnt == K_IO_ON)  ct.io  <= 1'b1;
            if (cnt == K_LIVE) begin
              ct.clk <= 1'b1;
              ct.rst <= 1'b1;
              ct.act <= 1'b1;
              state  <= SQ_LIVE;
            end
          end
        end
        SQ_DRAIN: begin
          if (cnt == K_CLK_OFF) ct.clk <= 1'b0;
          if (cnt == K_IO_OFF)  ct.io  <= 1'b0;
          if (cnt == K_VCC_OFF) ct.vcc <= 1'b0;
          if (done) begin
            ct.act <= 1'b0;
            state  <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assert_idle_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SQ_IDLE) |-> (ct == '0));
  assert_order_io_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ct.io |-> ct.vcc);
  assert_order_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ct.clk |-> ct.io);
  assert_rise_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ct.act) |-> (ct.clk && ct.rst && ct.io && ct.vcc));
  assert_rst_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ct.clk) |-> !ct.rst);
  assert_fault_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |-> (!ct.rst && state == SQ_DRAIN));
  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fault_pulse |=> !fault_pulse);
endmodule

// File: rtl/cseq_conv.sv
module cseq_conv (
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic done,
  input  logic idle,
  input  logic other_active,
  output logic conv_en
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conv_en <= 1'b0;
    end else if (accept && !other_active) begin
      conv_en <= 1'b1;
    end else if ((done || idle) && !other_active) begin
      conv_en <= 1'b0;
    end
  end

  assert_conv_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_en && other_active) |=> conv_en);
endmodule

// File: rtl/card_contact_seq.sv
module card_contact_seq
  import cseq_pkg::*;
#(
  parameter int T_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic card_present,
  input  logic supply_alarm,
  input  logic vcc_overcur,
  input  logic rst_overcur,
  input  logic overheat,
  input  logic other_active,
  output logic conv_en,
  output logic vcc_en,
  output logic io_en,
  output logic clk_en,
  output logic rst_en,
  output logic active,
  output logic fault_pulse
);
  localparam int CW = $clog2(4 * T_CYC + 1);

  sq_state_t     state;
  contact_t      ct;
  logic [CW-1:0] cnt;
  logic          accept, stop, emerg, done;

  cseq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .state(state), .start_req(start_req),
    .card_present(card_present), .supply_alarm(supply_alarm),
    .vcc_overcur(vcc_overcur), .rst_overcur(rst_overcur), .overheat(overheat),
    .accept(accept), .stop(stop), .emerg(emerg)
  );

  cseq_timer #(.CW(CW), .CMAX(4 * T_CYC - 1)) u_timer (
    .clk(clk), .rst_n(rst_n), .clear(accept | stop | emerg), .cnt(cnt)
  );

  cseq_fsm #(.T_CYC(T_CYC), .CW(CW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .accept(accept), .stop(stop), .emerg(emerg),
    .cnt(cnt), .state(state), .ct(ct), .fault_pulse(fault_pulse), .done(done)
  );

  cseq_conv u_conv (
    .clk(clk), .rst_n(rst_n), .accept(accept), .done(done),
    .idle(state == SQ_IDLE), .other_active(other_active), .conv_en(conv_en)
  );

  assign vcc_en = ct.vcc;
  assign io_en  = ct.io;
  assign clk_en = ct.clk;
  assign rst_en = ct.rst;
  assign active = ct.act;
endmodule

// File: tb/card_contact_seq_tb.sv
module card_contact_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TB_T = 16;
  localparam int H = TB_T / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, card_present = 1'b1, supply_alarm = 1'b0;
  logic vcc_overcur = 1'b0, rst_overcur = 1'b0, overheat = 1'b0, other_active = 1'b0;
  logic conv_en, vcc_en, io_en, clk_en, rst_en, active, fault_pulse;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  card_contact_seq #(.T_CYC(TB_T)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .card_present(card_present),
    .supply_alarm(supply_alarm), .vcc_overcur(vcc_overcur), .rst_overcur(rst_overcur),
    .overheat(overheat), .other_active(other_active), .conv_en(conv_en),
    .vcc_en(vcc_en), .io_en(io_en), .clk_en(clk_en), .rst_en(rst_en),
    .active(active), .fault_pulse(fault_pulse)
  );

  // Bit order: conv, vcc, io, clk, rst, active, fault
  function automatic logic [6:0] obs();
    return {conv_en, vcc_en, io_en, clk_en, rst_en, active, fault_pulse};
  endfunction

  task automatic chk(string tag, logic [6:0] got, logic [6:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s at %0t: got=%b exp=%b", tag, $time, got, exp);
    end
  endtask

  function automatic logic [6:0] act_exp(int j, logic oth);
    logic on;
    on = (j >= 8 * H);
    return {~oth, (j >= 3 * H), (j >= 7 * H), on, on, on, 1'b0};
  endfunction

  task automatic idle_check(int n, string tag);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(tag, obs(), 7'b0);
    end
  endtask

  // Called at a negedge: raise the request, then check each following cycle.
  task automatic run_act(int steps, logic oth, string tag);
    other_active = oth;
    start_req = 1'b1;
    for (int k = 1; k <= steps; k++) begin
      @(negedge clk);
      chk(tag, obs(), act_exp(k - 1, oth));
    end
  endtask

  // kind: 0 host stop, 1 vcc overcur, 2 rst overcur, 3 overheat, 4 alarm, 5 removal
  task automatic run_deact(logic [6:0] snap, int kind, int raise_at, logic oth, string tag);
    logic [6:0] e;
    other_active = oth;
    case (kind)
      0: start_req = 1'b0;
      1: vcc_overcur = 1'b1;
      2: rst_overcur = 1'b1;
      3: overheat = 1'b1;
      4: supply_alarm = 1'b1;
      default: card_present = 1'b0;
    endcase
    for (int k = 1; k <= 7 * H + 1; k++) begin
      int j;
      @(negedge clk);
      j = k - 1;
      e = {snap[6] && (j < 7 * H || oth), snap[5] && (j < 3 * H), snap[4] && (j < 2 * H),
           snap[3] && (j < H), 1'b0, snap[1] && (j < 7 * H), (kind != 0) && (j == 0)};
      chk(tag, obs(), e);
      if (k == raise_at) start_req = 1'b1;
    end
    vcc_overcur = 1'b0; rst_overcur = 1'b0; overheat = 1'b0;
    supply_alarm = 1'b0; card_present = 1'b1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int stops[10];
    stops = '{1, 2, 3 * H - 1, 3 * H, 3 * H + 1, 7 * H, 7 * H + 1, 8 * H - 1, 8 * H, 8 * H + 1};

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 in reset", obs(), 7'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", obs(), 7'b0);

    // R2 qualification
    start_req = 1'b1; card_present = 1'b0;
    idle_check(20, "R2 absent");
    card_present = 1'b1; supply_alarm = 1'b1;
    idle_check(20, "R2 alarm");
    start_req = 1'b0; supply_alarm = 1'b0;
    @(negedge clk);

    // R11 faults ignored while idle
    vcc_overcur = 1'b1; idle_check(3, "R11 vcc"); vcc_overcur = 1'b0;
    rst_overcur = 1'b1; idle_check(3, "R11 rst"); rst_overcur = 1'b0;
    overheat = 1'b1;    idle_check(3, "R11 heat"); overheat = 1'b0;
    card_present = 1'b0; idle_check(3, "R11 removal"); card_present = 1'b1;

    // R3 activation timing, R5 deactivation timing
    run_act(8 * H + 4, 1'b0, "R3");
    run_deact(act_exp(8 * H + 3, 1'b0), 0, 0, 1'b0, "R5");
    idle_check(2, "R5 idle");

    // R4 converter step skipped
    run_act(8 * H + 2, 1'b1, "R4");
    run_deact(act_exp(8 * H + 1, 1'b1), 0, 0, 1'b0, "R4");
    idle_check(2, "R4 idle");

    // R6 converter held while other slot active
    run_act(8 * H + 2, 1'b0, "R6");
    run_deact(act_exp(8 * H + 1, 1'b0), 0, 0, 1'b1, "R6");
    @(negedge clk);
    chk("R6 hold", obs(), 7'b1000000);
    other_active = 1'b0;
    @(negedge clk);
    chk("R6 release", obs(), 7'b0);

    // R10 stop swept across activation step boundaries
    foreach (stops[i]) begin
      run_act(stops[i], 1'b0, "R10");
      run_deact(act_exp(stops[i] - 1, 1'b0), 0, 0, 1'b0, "R10");
    end

    // R7 every fault source in ramp and in session, R8 lockout after each
    for (int kind = 1; kind <= 5; kind++) begin
      for (int ph = 0; ph < 2; ph++) begin
        int s;
        s = (ph == 0) ? 3 * H + 2 : 8 * H + 3;
        run_act(s, 1'b0, "R7");
        run_deact(act_exp(s - 1, 1'b0), kind, 0, 1'b0, "R7");
        idle_check(12, "R8 locked");
        start_req = 1'b0;
        idle_check(1, "R8 unlock");
      end
    end
    run_act(8 * H + 2, 1'b0, "R8 restart");
    run_deact(act_exp(8 * H + 1, 1'b0), 0, 0, 1'b0, "R8");

    // R9 request during shutdown is held off, then accepted
    run_act(8 * H + 2, 1'b0, "R9");
    run_deact(act_exp(8 * H + 1, 1'b0), 0, H, 1'b0, "R9");
    run_act(8 * H + 2, 1'b0, "R9 resume");
    run_deact(act_exp(8 * H + 1, 1'b0), 0, 0, 1'b0, "R9");
    idle_check(2, "R9 idle");

    finish_run();
  end
endmodule